// File: doc/BRIEF.md
# Store-Multiple Register Transfer Sequencer

This block carries out a block store of a set of registers to memory, one 32-bit word per transfer. A start pulse supplies a 16-bit register-select mask, the index of the register that holds the base address, a writeback flag and a mode flag. The block reads the base register through its register read port. It then walks the mask from the lowest selected register to the highest. For each register it reads the value through the same port and issues one word write over a request/ready memory interface.

The base address advances by one word after every accepted write. When the last write is accepted, a one-cycle completion pulse is raised. If writeback was requested, the pulse comes with a writeback enable and the updated base value (the original base plus four bytes per selected register).

The top bit of the mask selects the program counter. Its value comes from a dedicated input, and it is always stored last. When the base register is in the list with writeback and is not the first register stored, a fixed filler word is written in its slot. In compact mode, masks that select the stack pointer or the program counter are refused. A memory error response stops the sequence at once and suppresses writeback.

Top module: `stm_sequencer`

## Requirements
- R1: Selected registers are stored in ascending index order. The first one is written at the base register's value, and each later one at the previous address plus 4.
- R2: With writeback set, `done_o` comes with `wb_en_o`=1 and `wb_data_o` = original base + 4 × (number of set mask bits). With writeback clear, `wb_en_o` stays 0.
- R3: If the base register is selected, writeback is set and the base is not the lowest set mask bit, a filler word is stored in the base's slot. Its value is not specified, but its address follows R1. Without writeback, the base register's real value is stored.
- R4: If the base register is the lowest set mask bit, its original value is stored at the base address.
- R5: Mask bit 15 selects the program counter. Its word is taken from `pc_val_i` and written last, at the highest address. Bits 0–14 select registers read through `rf_addr_o`/`rf_data_i`.
- R6: In compact mode (`compact_i`=1), a mask with bit 13 or bit 15 set raises `illegal_o` for one cycle. No write is issued and no completion pulse is given.
- R7: In compact mode, a mask with exactly one set bit produces a single write at the base address. With writeback set, the new base is the original base + 4.
- R8: An all-zero mask raises `illegal_o` for one cycle. No write is issued and `wb_en_o` stays 0.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, `mem_req_o`, `mem_addr_o` and `mem_wdata_o` hold their values into the next cycle.
- R10: `mem_err_i` high while a request is pending ends the sequence. `abort_o` pulses in the next cycle, no further write is issued, and neither `done_o` nor `wb_en_o` is raised. An error takes priority over a simultaneous `mem_ready_i`.
- R11: `done_o` is high for exactly one cycle: the cycle after the clock edge that accepted the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| mask_i | input | 16 | Register-select mask, bit i selects register i |
| base_idx_i | input | 4 | Index of the base register |
| wback_i | input | 1 | Request base writeback |
| compact_i | input | 1 | Compact mode select |
| pc_val_i | input | 32 | Word stored for mask bit 15 |
| rf_addr_o | output | 4 | Register read index |
| rf_data_i | input | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Write accepted this cycle |
| mem_err_i | input | 1 | Error response for the pending write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| abort_o | output | 1 | One-cycle abort pulse after a memory error |
| illegal_o | output | 1 | One-cycle refused-request pulse |
| wb_en_o | output | 1 | Base writeback enable, with `done_o` |
| wb_data_o | output | 32 | Updated base value |

## Verification
Two events can land on the same clock edge: acceptance of the final write, which would start the completion and writeback pulse, and an error response, which must abort. The bench provokes this by holding `mem_ready_i` high while raising `mem_err_i` on the last word of a two-register store. It then judges that `abort_o` pulses, while `done_o` and `wb_en_o` never rise and the accepted-write count stops at one. A mid-list error on a longer store, and a normal store issued straight afterwards, confirm that the block returns cleanly to idle.

// File: rtl/stm_pkg.sv
package stm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_WRITE = 2'd2
   } seq_state_e;
endpackage

// File: rtl/stm_popcount.sv
module stm_popcount #(
   parameter int N = 16,
   localparam int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec_i,
   output logic [CW-1:0] count_o
);
   if (N < 1) begin : g_bad_n
      $error("stm_popcount: N must be at least 1");
   end

   logic [CW-1:0] part [N+1];
   assign part[0] = '0;

   for (genvar g = 0; g < N; g++) begin : g_sum
      assign part[g+1] = part[g] + CW'(vec_i[g]);
   end

   assign count_o = part[N];
endmodule

// File: rtl/stm_lowest_sel.sv
module stm_lowest_sel #(
   parameter int N = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   if (N < 2) begin : g_bad_n
      $error("stm_lowest_sel: N must be at least 2");
   end

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end

   assign any_o = |vec_i;
endmodule

// File: rtl/stm_word_pick.sv
module stm_word_pick #(
   parameter int              NREG        = 16,
   parameter int              DW          = 32,
   parameter logic [DW-1:0]   FILLER_WORD = '1,
   localparam int             IW          = $clog2(NREG),
   localparam int             PC_BIT      = NREG - 1
) (
   input  logic [IW-1:0] idx_i,
   input  logic [IW-1:0] base_idx_i,
   input  logic          wback_i,
   input  logic [IW-1:0] lowest_idx_i,
   input  logic [DW-1:0] rf_data_i,
   input  logic [DW-1:0] pc_val_i,
   output logic [DW-1:0] word_o
);
   logic is_pc;
   logic base_clobbered;

   assign is_pc          = (idx_i == IW'(PC_BIT));
   assign base_clobbered = wback_i && (idx_i == base_idx_i) && (idx_i != lowest_idx_i);

   always_comb begin
      if (is_pc)               word_o = pc_val_i;
      else if (base_clobbered) word_o = FILLER_WORD;
      else                     word_o = rf_data_i;
   end
endmodule

// File: rtl/stm_sequencer.sv
module stm_sequencer
   import stm_pkg::*;
#(
   parameter int            NREG        = 16,
   parameter int            DW          = 32,
   parameter int            SP_BIT      = 13,
   parameter bit            COMPACT_EN  = 1'b1,
   parameter logic [DW-1:0] FILLER_WORD = 32'hBAD0_F111,
   localparam int           IW          = $clog2(NREG),
   localparam int           CW          = $clog2(NREG + 1),
   localparam int           PC_BIT      = NREG - 1,
   localparam int           STEP        = DW / 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [NREG-1:0] mask_i,
   input  logic [IW-1:0]   base_idx_i,
   input  logic            wback_i,
   input  logic            compact_i,
   input  logic [DW-1:0]   pc_val_i,
   output logic [IW-1:0]   rf_addr_o,
   input  logic [DW-1:0]   rf_data_i,
   output logic            mem_req_o,
   output logic [DW-1:0]   mem_addr_o,
   output logic [DW-1:0]   mem_wdata_o,
   input  logic            mem_ready_i,
   input  logic            mem_err_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            abort_o,
   output logic            illegal_o,
   output logic            wb_en_o,
   output logic [DW-1:0]   wb_data_o
);
   if (DW % 8 != 0) begin : g_bad_dw
      $error("stm_sequencer: DW must be a whole number of bytes");
   end
   if (NREG < 4 || (1 << IW) != NREG) begin : g_bad_nreg
      $error("stm_sequencer: NREG must be a power of two, at least 4");
   end
   if (SP_BIT < 0 || SP_BIT >= PC_BIT) begin : g_bad_sp
      $error("stm_sequencer: SP_BIT must lie below the program counter bit");
   end

   seq_state_e      state_q;
   logic [NREG-1:0] pend_q;
   logic [IW-1:0]   base_idx_q;
   logic [IW-1:0]   lowest_q;
   logic            wback_q;
   logic [DW-1:0]   addr_q;
   logic [DW-1:0]   wdata_q;
   logic [DW-1:0]   wb_val_q;
   logic            done_q, abort_q, illegal_q, wb_en_q;

   // Start-time decode of the incoming mask
   logic          mask_any;
   logic [IW-1:0] mask_low;
   logic [CW-1:0] mask_cnt;
   logic          compact_bad;
   logic          req_bad;

   stm_lowest_sel #(.N(NREG)) u_first (
      .vec_i (mask_i),
      .any_o (mask_any),
      .idx_o (mask_low)
   );

   stm_popcount #(.N(NREG)) u_count (
      .vec_i   (mask_i),
      .count_o (mask_cnt)
   );

   if (COMPACT_EN) begin : g_compact
      assign compact_bad = compact_i && (mask_i[SP_BIT] || mask_i[PC_BIT]);
   end else begin : g_no_compact
      logic unused_compact;
      assign unused_compact = compact_i;
      assign compact_bad    = 1'b0;
   end

   assign req_bad = !mask_any || compact_bad;

   // Walk of the remaining mask bits
   logic          pend_any;
   logic [IW-1:0] nxt_idx;
   logic [DW-1:0] nxt_word;

   stm_lowest_sel #(.N(NREG)) u_next (
      .vec_i (pend_q),
      .any_o (pend_any),
      .idx_o (nxt_idx)
   );

   stm_word_pick #(
      .NREG        (NREG),
      .DW          (DW),
      .FILLER_WORD (FILLER_WORD)
   ) u_pick (
      .idx_i        (nxt_idx),
      .base_idx_i   (base_idx_q),
      .wback_i      (wback_q),
      .lowest_idx_i (lowest_q),
      .rf_data_i    (rf_data_i),
      .pc_val_i     (pc_val_i),
      .word_o       (nxt_word)
   );

   logic [NREG-1:0] nxt_clear;
   assign nxt_clear = ~(NREG'(1) << nxt_idx);

   assign rf_addr_o = (state_q == ST_IDLE) ? base_idx_i : nxt_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pend_q     <= '0;
         base_idx_q <= '0;
         lowest_q   <= '0;
         wback_q    <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
         wb_val_q   <= '0;
         done_q     <= 1'b0;
         abort_q    <= 1'b0;
         illegal_q  <= 1'b0;
         wb_en_q    <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         abort_q   <= 1'b0;
         illegal_q <= 1'b0;
         wb_en_q   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (req_bad) begin
                     illegal_q <= 1'b1;
                  end else begin
                     pend_q     <= mask_i;
                     base_idx_q <= base_idx_i;
                     lowest_q   <= mask_low;
                     wback_q    <= wback_i;
                     addr_q     <= rf_data_i;
                     wb_val_q   <= rf_data_i + DW'(STEP) * DW'(mask_cnt);
                     state_q    <= ST_LOAD;
                  end
               end
            end
            ST_LOAD: begin
               wdata_q <= nxt_word;
               pend_q  <= pend_q & nxt_clear;
               state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (mem_err_i) begin
                  abort_q <= 1'b1;
                  pend_q  <= '0;
                  state_q <= ST_IDLE;
               end else if (mem_ready_i) begin
                  if (!pend_any) begin
                     done_q  <= 1'b1;
                     wb_en_q <= wback_q;
                     state_q <= ST_IDLE;
                  end else begin
                     wdata_q <= nxt_word;
                     pend_q  <= pend_q & nxt_clear;
                     addr_q  <= addr_q + DW'(STEP);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o   = (state_q == ST_WRITE);
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = wdata_q;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign abort_o     = abort_q;
   assign illegal_o   = illegal_q;
   assign wb_en_o     = wb_en_q;
   assign wb_data_o   = wb_val_q;

   // R9: a stalled write holds its request, address and data
   p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i && !mem_err_i)
      |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

   // R1: the write that follows an accepted one is one word higher
   p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ready_i && !mem_err_i)
      |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + DW'(STEP)));

   // R10: an error response ends the sequence with an abort pulse
   p_err_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_err_i) |=> (abort_o && !mem_req_o && !done_o && !wb_en_o));

   // R11: completion pulse is one cycle wide
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R2: writeback enable only accompanies completion
   p_wb_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> done_o);

   // R8: a refused request issues no write and no completion
   p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (!mem_req_o && !done_o && !busy_o));

   // R10, R11: result pulses are mutually exclusive
   p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, abort_o, illegal_o}));
endmodule

// File: tb/stm_sequencer_tb.sv
module stm_sequencer_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] mask = '0;
   logic [3:0]  bidx = '0;
   logic        wback = 1'b0;
   logic        compact = 1'b0;
   logic [31:0] pc_val = 32'h0000_8ACE;
   logic [3:0]  rf_addr;
   logic [31:0] rf_data;
   logic [31:0] regs [16];
   logic        mem_req, mem_ready = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_addr, mem_wdata, wb_data;
   logic        busy, done, abort_p, illegal, wb_en;

   assign rf_data = regs[rf_addr];

   stm_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask),
      .base_idx_i(bidx), .wback_i(wback), .compact_i(compact), .pc_val_i(pc_val),
      .rf_addr_o(rf_addr), .rf_data_i(rf_data),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .mem_ready_i(mem_ready), .mem_err_i(mem_err),
      .busy_o(busy), .done_o(done), .abort_o(abort_p), .illegal_o(illegal),
      .wb_en_o(wb_en), .wb_data_o(wb_data)
   );

   int n_chk = 0, n_bad = 0;
   int tick = 0, smode = 0, err_at = -1, nwr0 = 0;
   int nwr = 0, last_acc = 0, done_tick = 0;
   int done_cnt = 0, abort_cnt = 0, ill_cnt = 0, hold_viol = 0;
   logic [31:0] wa [256];
   logic [31:0] wd [256];
   logic        wb_en_seen = 1'b0;
   logic [31:0] wb_seen = '0;
   logic        pend_wait = 1'b0;
   logic [31:0] pa = '0, pd = '0;

   // Memory model and pulse monitor, all on the falling edge
   always @(negedge clk) begin
      tick++;
      if (!rst_n) begin
         mem_ready = 1'b0;
         mem_err   = 1'b0;
         pend_wait = 1'b0;
      end else begin
         mem_ready = (smode == 0) ? 1'b1 : ((tick % 3) == 0);
         mem_err   = (err_at >= 0) && ((nwr - nwr0) == err_at) && mem_req;
         if (mem_req && pend_wait && (mem_addr != pa || mem_wdata != pd)) hold_viol++;
         if (mem_req && mem_ready && !mem_err) begin
            wa[nwr & 255] = mem_addr;
            wd[nwr & 255] = mem_wdata;
            nwr++;
            last_acc  = tick;
            pend_wait = 1'b0;
         end else if (mem_req && !mem_err) begin
            pend_wait = 1'b1;
            pa = mem_addr;
            pd = mem_wdata;
         end else begin
            pend_wait = 1'b0;
         end
         if (done) begin
            done_cnt++;
            done_tick  = tick;
            wb_en_seen = wb_en;
            wb_seen    = wb_data;
         end
         if (abort_p) abort_cnt++;
         if (illegal) ill_cnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   int d0, a0, i0;

   task automatic run_op(input logic [15:0] m, input logic [3:0] b, input logic w,
                         input logic c, input logic [31:0] base, input int sm, input int ea);
      @(negedge clk); #1;
      regs[b] = base;
      smode  = sm;
      err_at = ea;
      nwr0   = nwr;
      d0 = done_cnt; a0 = abort_cnt; i0 = ill_cnt;
      mask = m; bidx = b; wback = w; compact = c; start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      for (int k = 0; k < 300; k++) begin
         if (done_cnt != d0 || abort_cnt != a0 || ill_cnt != i0) break;
         @(negedge clk); #1;
      end
      repeat (4) @(negedge clk);
      #1;
   endtask

   task automatic check_list(input string tag, input logic [15:0] m, input logic [3:0] b,
                             input logic w, input logic [31:0] base);
      int k;
      int low;
      k = 0;
      low = -1;
      for (int i = 0; i < 16; i++) if (m[i] && low < 0) low = i;
      for (int i = 0; i < 16; i++) begin
         if (m[i]) begin
            chk(wa[(nwr0 + k) & 255] == base + 32'(4 * k), "R1", {tag, " address"},
                wa[(nwr0 + k) & 255], base + 32'(4 * k));
            if (i == 15)
               chk(wd[(nwr0 + k) & 255] == pc_val, "R5", {tag, " pc word"},
                   wd[(nwr0 + k) & 255], pc_val);
            else if (!(i == int'(b) && w && i != low))
               chk(wd[(nwr0 + k) & 255] == regs[i], tag, "data word",
                   wd[(nwr0 + k) & 255], regs[i]);
            k++;
         end
      end
      chk((nwr - nwr0) == k, tag, "write count", 32'(nwr - nwr0), 32'(k));
   endtask

   task automatic t_reset();
      chk(!mem_req && !busy && !done && !abort_p && !illegal && !wb_en, "R11",
          "reset outputs idle", {26'd0, mem_req, busy, done, abort_p, illegal, wb_en}, 32'd0);
   endtask

   task automatic t_sparse();
      run_op(16'h1249, 4'd2, 1'b1, 1'b0, 32'h0000_1000, 0, -1);
      check_list("R1", 16'h1249, 4'd2, 1'b1, 32'h0000_1000);
      chk(wb_en_seen && wb_seen == 32'h0000_1014, "R2", "writeback value", wb_seen, 32'h0000_1014);
      chk((done_cnt - d0) == 1, "R11", "one done pulse", 32'(done_cnt - d0), 32'd1);
      chk(done_tick == last_acc + 1, "R11", "done follows last accept",
          32'(done_tick - last_acc), 32'd1);
   endtask

   task automatic t_stall();
      run_op(16'h00F0, 4'd1, 1'b0, 1'b0, 32'h0000_2200, 1, -1);
      check_list("R9", 16'h00F0, 4'd1, 1'b0, 32'h0000_2200);
      chk(hold_viol == 0, "R9", "stalled write held", 32'(hold_viol), 32'd0);
      chk(!wb_en_seen && (done_cnt - d0) == 1, "R2", "no writeback when clear",
          {31'd0, wb_en_seen}, 32'd0);
   endtask

   task automatic t_base_mid();
      run_op(16'h00A1, 4'd5, 1'b1, 1'b0, 32'h0000_3000, 0, -1);
      check_list("R3", 16'h00A1, 4'd5, 1'b1, 32'h0000_3000);
      chk(wb_en_seen && wb_seen == 32'h0000_300C, "R2", "writeback with base in list",
          wb_seen, 32'h0000_300C);
      run_op(16'h00A1, 4'd5, 1'b0, 1'b0, 32'h0000_3400, 0, -1);
      check_list("R3", 16'h00A1, 4'd5, 1'b0, 32'h0000_3400);
      chk(wd[(nwr0 + 1) & 255] == 32'h0000_3400, "R3", "real base without writeback",
          wd[(nwr0 + 1) & 255], 32'h0000_3400);
   endtask

   task automatic t_base_low();
      run_op(16'h0310, 4'd4, 1'b1, 1'b0, 32'h0000_4000, 0, -1);
      check_list("R4", 16'h0310, 4'd4, 1'b1, 32'h0000_4000);
      chk(wd[nwr0 & 255] == 32'h0000_4000, "R4", "original base stored",
          wd[nwr0 & 255], 32'h0000_4000);
   endtask

   task automatic t_pc();
      run_op(16'hA001, 4'd3, 1'b1, 1'b0, 32'h0000_5000, 1, -1);
      check_list("R5", 16'hA001, 4'd3, 1'b1, 32'h0000_5000);
      chk(wa[(nwr - 1) & 255] == 32'h0000_5008, "R5", "pc at highest address",
          wa[(nwr - 1) & 255], 32'h0000_5008);
   endtask

   task automatic t_compact_bad();
      run_op(16'h2001, 4'd0, 1'b1, 1'b1, 32'h0000_6000, 0, -1);
      chk((ill_cnt - i0) == 1 && (done_cnt - d0) == 0, "R6", "stack pointer refused",
          32'(ill_cnt - i0), 32'd1);
      chk(nwr == nwr0, "R6", "no write for stack pointer", 32'(nwr - nwr0), 32'd0);
      run_op(16'h8000, 4'd0, 1'b0, 1'b1, 32'h0000_6000, 0, -1);
      chk((ill_cnt - i0) == 1 && nwr == nwr0, "R6", "program counter refused",
          32'(nwr - nwr0), 32'd0);
   endtask

   task automatic t_compact_single();
      run_op(16'h0040, 4'd7, 1'b1, 1'b1, 32'h0000_7000, 0, -1);
      check_list("R7", 16'h0040, 4'd7, 1'b1, 32'h0000_7000);
      chk(wb_en_seen && wb_seen == 32'h0000_7004, "R7", "single store writeback",
          wb_seen, 32'h0000_7004);
   endtask

   task automatic t_zero();
      run_op(16'h0000, 4'd1, 1'b1, 1'b0, 32'h0000_8000, 0, -1);
      chk((ill_cnt - i0) == 1, "R8", "empty mask flagged", 32'(ill_cnt - i0), 32'd1);
      chk(nwr == nwr0 && (done_cnt - d0) == 0, "R8", "empty mask no write",
          32'(nwr - nwr0), 32'd0);
   endtask

   task automatic t_abort();
      run_op(16'h000F, 4'd8, 1'b1, 1'b0, 32'h0000_9000, 0, 1);
      chk((abort_cnt - a0) == 1 && (done_cnt - d0) == 0, "R10", "mid-list abort",
          32'(abort_cnt - a0), 32'd1);
      chk((nwr - nwr0) == 1, "R10", "writes stop at error", 32'(nwr - nwr0), 32'd1);
      run_op(16'h0003, 4'd8, 1'b1, 1'b0, 32'h0000_9100, 0, 1);
      chk((abort_cnt - a0) == 1 && (done_cnt - d0) == 0, "R10", "error beats last ready",
          32'(done_cnt - d0), 32'd0);
      chk((nwr - nwr0) == 1, "R10", "last word not counted", 32'(nwr - nwr0), 32'd1);
      run_op(16'h0006, 4'd8, 1'b1, 1'b0, 32'h0000_9200, 0, -1);
      check_list("R10", 16'h0006, 4'd8, 1'b1, 32'h0000_9200);
      chk(wb_en_seen && wb_seen == 32'h0000_9208, "R2", "store after abort",
          wb_seen, 32'h0000_9208);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) regs[i] = 32'hA000_0000 + 32'(i * 32'h111);
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_sparse();
      t_stall();
      t_base_mid();
      t_base_low();
      t_pc();
      t_compact_bad();
      t_compact_single();
      t_zero();
      t_abort();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule